// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block runs the external memory bus of an 8-bit microcontroller core. It counts oscillator periods into machine cycles of twelve periods. In each cycle it runs one command from the core: two program-byte fetches, one data-memory read, or one data-memory write. The low address byte and the data share one 8-bit port, and a second port carries the high address byte. An address latch strobe tells outside logic when the shared port holds the low address. Program bytes are read with a program-store strobe, and data memory is read and written with separate read and write strobes. All of these strobes are active low.

The core places its command on the inputs during the last oscillator period of a machine cycle, while `cyc_last` is high. The block samples the command at the end of that period. A fetch command reads the byte at the given address and the byte that follows it. When the external-access input is low, any fetch address below 0x2000 is served from an internal ROM through `rom_addr`/`rom_data`, and the bus strobes stay quiet. Results go back to the core as single-period pulses on `fetch_valid` and `rd_valid`.

Top module: `xbus_ctrl`

## Requirements
- R1: Phases are numbered 0 to 11 within a machine cycle. A machine cycle is 12 clock periods long, and `cyc_last` is high only in phase 11. `cyc_last` is also high while reset is asserted and in the first period after reset is released.
- R2: The command is sampled only at the clock edge that ends a `cyc_last` period. The fields sampled are `cmd_kind` (0 idle, 1 fetch, 2 data read, 3 data write), `cmd_addr`, `cmd_wdata` and `ext_access`. Changes to these inputs at any other time have no effect on the pins.
- R3: In a fetch cycle, half 0 is phases 0–5 and uses the command address A. Half 1 is phases 6–11 and uses A+1, wrapping from 0xFFFF to 0x0000. At half offsets 0–1, `ale` is high. `p2_out` carries the high byte of the half's address for the whole half. On an external half, `p0_out` is driven with the low address byte at offsets 0–2.
- R4: On an external fetch half, `psen_n` is low at offsets 3–5 and the shared port is not driven. The byte on `p0_in` during offset 5 is returned on `fetch_data`, with `fetch_valid` high for one period: phase 6 for half 0, and phase 0 of the next cycle for half 1.
- R5: When `ext_access` is 0, a fetch half whose address is below 0x2000 is internal. `psen_n` stays high and the port is not driven. `rom_addr` equals the half's address from offset 0 on, and `rom_data` is returned with the same timing as R4. Each half is decided on its own address.
- R6: When `ext_access` is 1, every fetch half is external, whatever its address.
- R7: In a data read cycle, `ale` is high only in phases 0–1 and the low address is driven in phases 0–2. `rd_n` is low in phases 3–8, and the port is floated during that time. `p0_in` during phase 8 is returned on `rd_data`, with `rd_valid` high in phase 9. `psen_n` stays high.
- R8: In a data write cycle, addressing is the same as in R7. `wr_n` is low in phases 3–8, and `p0_out` is driven with the write data during all of those phases.
- R9: In an idle cycle, `ale` is low, all strobes are high and the port is not driven.
- R10: While reset is asserted, `ale`, `p0_oe`, `fetch_valid` and `rd_valid` are 0, and `psen_n`, `rd_n` and `wr_n` are 1.
- R11: At most one of `psen_n`, `rd_n` and `wr_n` is low at a time. The shared port is never driven while `psen_n` or `rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_access | input | 1 | 1 sends all fetches to the external bus |
| cmd_kind | input | 2 | Command: 0 idle, 1 fetch, 2 read, 3 write |
| cmd_addr | input | 16 | Fetch or data address |
| cmd_wdata | input | 8 | Write data |
| cyc_last | output | 1 | Last period of the machine cycle; the command is sampled at its end |
| fetch_valid | output | 1 | Fetched byte valid pulse |
| fetch_data | output | 8 | Fetched byte |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Data read from external memory |
| rom_addr | output | 16 | Internal ROM address |
| rom_data | input | 8 | Internal ROM byte |
| p0_out | output | 8 | Shared port output value |
| p0_oe | output | 1 | Shared port output enable |
| p0_in | input | 8 | Shared port input value |
| p2_out | output | 8 | High address port |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The bench builds the block with its default parameters: two periods per state, six states per machine cycle, and the internal program limit at 0x2000. With these values, a fetch at 0x1FFF straddles the limit, so one half goes to ROM and the other goes to the bus. A fetch at 0xFFFF has a second half that wraps to an internal address. Directed cycles cover both of these cases. Random cycles then mix all four commands and both settings of `ext_access`, and scramble the command inputs inside each cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int XB_AW = 16;
  localparam int XB_DW = 8;
  localparam int XB_HW = XB_AW - XB_DW;

  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_FETCH  = 2'd1,
    CMD_DREAD  = 2'd2,
    CMD_DWRITE = 2'd3
  } cmd_e;

  typedef struct packed {
    cmd_e              kind;
    logic              ext;
    logic [XB_AW-1:0]  addr;
    logic [XB_DW-1:0]  wdata;
  } cmd_t;

  typedef struct packed {
    logic              ale;
    logic              psen_n;
    logic              rd_n;
    logic              wr_n;
    logic              p0_oe;
    logic [XB_DW-1:0]  p0;
    logic [XB_HW-1:0]  p2;
    logic [XB_AW-1:0]  rom_addr;
    logic              cap_fetch;
    logic              cap_ext;
    logic              cap_read;
  } pins_t;

  localparam cmd_t CMD_NONE = '{kind: CMD_IDLE, ext: 1'b0, addr: '0, wdata: '0};

  localparam pins_t PINS_IDLE = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                  p0_oe: 1'b0, p0: '0, p2: '0, rom_addr: '0,
                                  cap_fetch: 1'b0, cap_ext: 1'b0, cap_read: 1'b0};
endpackage

// File: rtl/xbus_phase.sv
module xbus_phase #(
  parameter int PHASES = 12,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] ph_nxt,
  output logic          cyc_last
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] ph;

  assign cyc_last = (ph == LAST);
  assign ph_nxt   = cyc_last ? '0 : ph + 1'b1;

  // Reset parks the counter on the final phase so the first edge after reset
  // samples a command and opens phase 0.
  always_ff @(posedge clk) begin
    if (rst) ph <= LAST;
    else     ph <= ph_nxt;
  end

  AST_CYCLE_WRAP: assert property (@(posedge clk) disable iff (rst)
    cyc_last |=> (ph == '0));                              // R1
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    !cyc_last |=> (ph == $past(ph) + 1'b1));               // R1
endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int                STATE_OSC = 2,
  parameter int                PHASES    = 12,
  parameter logic [XB_AW-1:0]  ROM_LIMIT = 16'h2000,
  localparam int PW = $clog2(PHASES)
) (
  input  cmd_t           cmd,
  input  logic [PW-1:0]  ph,
  output pins_t          pins
);
  localparam int HALF = PHASES / 2;
  localparam logic [PW-1:0] HALF_P  = PW'(HALF);
  localparam logic [PW-1:0] ALE_P   = PW'(STATE_OSC);          // ale high below this offset
  localparam logic [PW-1:0] ADR_P   = PW'(STATE_OSC + 1);      // address held below this offset
  localparam logic [PW-1:0] STB_P   = PW'(HALF / 2);           // strobe start offset
  localparam logic [PW-1:0] OFSL_P  = PW'(HALF - 1);           // last offset of a half
  localparam logic [PW-1:0] DEND_P  = PW'(HALF / 2 + HALF - 1); // last data strobe phase

  logic             hi;
  logic [PW-1:0]    ofs;
  logic [XB_AW-1:0] fa;
  logic             ext;
  logic             dwin;

  always_comb begin
    hi   = (ph >= HALF_P);
    ofs  = hi ? (ph - HALF_P) : ph;
    fa   = cmd.addr + XB_AW'(hi);
    ext  = cmd.ext | (fa >= ROM_LIMIT);
    dwin = (ph >= STB_P) && (ph <= DEND_P);

    pins          = PINS_IDLE;
    pins.rom_addr = fa;

    case (cmd.kind)
      CMD_FETCH: begin
        pins.ale       = (ofs < ALE_P);
        pins.p2        = fa[XB_AW-1:XB_DW];
        pins.cap_fetch = (ofs == OFSL_P);
        pins.cap_ext   = ext;
        if (ext) begin
          pins.psen_n = !(ofs >= STB_P);
          if (ofs < ADR_P) begin
            pins.p0_oe = 1'b1;
            pins.p0    = fa[XB_DW-1:0];
          end
        end
      end
      CMD_DREAD, CMD_DWRITE: begin
        pins.ale = (ph < ALE_P);
        pins.p2  = cmd.addr[XB_AW-1:XB_DW];
        if (ph < ADR_P) begin
          pins.p0_oe = 1'b1;
          pins.p0    = cmd.addr[XB_DW-1:0];
        end
        if (cmd.kind == CMD_DREAD) begin
          pins.rd_n     = !dwin;
          pins.cap_read = (ph == DEND_P);
        end else begin
          pins.wr_n = !dwin;
          if (dwin) begin
            pins.p0_oe = 1'b1;
            pins.p0    = cmd.wdata;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
  import xbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_fetch,
  input  logic             cap_ext,
  input  logic             cap_read,
  input  logic [XB_DW-1:0] p0_in,
  input  logic [XB_DW-1:0] rom_data,
  output logic             fetch_valid,
  output logic [XB_DW-1:0] fetch_data,
  output logic             rd_valid,
  output logic [XB_DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_valid <= 1'b0;
      fetch_data  <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      fetch_valid <= cap_fetch;
      rd_valid    <= cap_read;
      if (cap_fetch) fetch_data <= cap_ext ? p0_in : rom_data;
      if (cap_read)  rd_data    <= p0_in;
    end
  end

  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> !fetch_valid);                          // R4
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);                                // R7
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int               STATE_OSC = 2,
  parameter int               STATES    = 6,
  parameter logic [XB_AW-1:0] ROM_LIMIT = 16'h2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_access,
  input  logic [1:0]       cmd_kind,
  input  logic [XB_AW-1:0] cmd_addr,
  input  logic [XB_DW-1:0] cmd_wdata,
  output logic             cyc_last,
  output logic             fetch_valid,
  output logic [XB_DW-1:0] fetch_data,
  output logic             rd_valid,
  output logic [XB_DW-1:0] rd_data,
  output logic [XB_AW-1:0] rom_addr,
  input  logic [XB_DW-1:0] rom_data,
  output logic [XB_DW-1:0] p0_out,
  output logic             p0_oe,
  input  logic [XB_DW-1:0] p0_in,
  output logic [XB_HW-1:0] p2_out,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n
);
  localparam int PHASES = STATE_OSC * STATES;
  localparam int PW     = $clog2(PHASES);

  logic [PW-1:0] ph_nxt;
  cmd_t          cmd_in, cmd_q, cmd_eff;
  pins_t         nxt;
  logic          cap_fetch, cap_ext, cap_read;

  xbus_phase #(.PHASES(PHASES)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .ph_nxt   (ph_nxt),
    .cyc_last (cyc_last)
  );

  assign cmd_in  = '{kind: cmd_e'(cmd_kind), ext: ext_access, addr: cmd_addr, wdata: cmd_wdata};
  // The phase about to begin is phase 0 of a new cycle when cyc_last is high.
  assign cmd_eff = cyc_last ? cmd_in : cmd_q;

  xbus_decode #(.STATE_OSC(STATE_OSC), .PHASES(PHASES), .ROM_LIMIT(ROM_LIMIT)) u_dec (
    .cmd  (cmd_eff),
    .ph   (ph_nxt),
    .pins (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= CMD_NONE;
      ale       <= 1'b0;
      psen_n    <= 1'b1;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      p0_oe     <= 1'b0;
      p0_out    <= '0;
      p2_out    <= '0;
      rom_addr  <= '0;
      cap_fetch <= 1'b0;
      cap_ext   <= 1'b0;
      cap_read  <= 1'b0;
    end else begin
      if (cyc_last) cmd_q <= cmd_in;
      ale       <= nxt.ale;
      psen_n    <= nxt.psen_n;
      rd_n      <= nxt.rd_n;
      wr_n      <= nxt.wr_n;
      p0_oe     <= nxt.p0_oe;
      p0_out    <= nxt.p0;
      p2_out    <= nxt.p2;
      rom_addr  <= nxt.rom_addr;
      cap_fetch <= nxt.cap_fetch;
      cap_ext   <= nxt.cap_ext;
      cap_read  <= nxt.cap_read;
    end
  end

  xbus_capture u_cap (
    .clk         (clk),
    .rst         (rst),
    .cap_fetch   (cap_fetch),
    .cap_ext     (cap_ext),
    .cap_read    (cap_read),
    .p0_in       (p0_in),
    .rom_data    (rom_data),
    .fetch_valid (fetch_valid),
    .fetch_data  (fetch_data),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);              // R11
  AST_FLOAT_ON_INPUT: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> !p0_oe);                         // R11
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ale |-> (psen_n && rd_n && wr_n));                      // R3
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> p0_oe);                                       // R8
  AST_READ_HAS_ADDR: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n) |-> $past(p0_oe));                          // R7
endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_access = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic [15:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        cyc_last, fetch_valid, rd_valid, p0_oe, ale, psen_n, rd_n, wr_n;
  logic [7:0]  fetch_data, rd_data, rom_data, p0_out, p0_in, p2_out;
  logic [15:0] rom_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  bit       fv_pend = 0;
  logic [7:0] fd_pend = '0;
  string    fd_tag = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] xprog(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5C;
  endfunction
  function automatic logic [7:0] xdata(input logic [15:0] a);
    return a[7:0] + {a[14:8], 1'b1};
  endfunction
  function automatic logic [7:0] rom_fn(input logic [15:0] a);
    return ~a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  assign rom_data = rom_fn(rom_addr);

  xbus_ctrl uut (
    .clk(clk), .rst(rst), .ext_access(ext_access), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cyc_last(cyc_last),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .rom_addr(rom_addr), .rom_data(rom_data),
    .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_ext(input logic ext, input logic [15:0] a);
    return ext || (a >= 16'h2000);
  endfunction

  // Called at a negedge inside a cyc_last period; runs one machine cycle.
  task automatic run_cycle(input logic [1:0] kind, input logic [15:0] addr,
                           input logic [7:0] wd, input logic ext);
    string ptag;
    chk("R1 cyc_last before command", {63'd0, cyc_last}, 64'd1);
    cmd_kind = kind; cmd_addr = addr; cmd_wdata = wd; ext_access = ext;
    ptag = (kind == 2'd0) ? "R9" : (kind == 2'd1) ? "R2 R3" : (kind == 2'd2) ? "R7" : "R8";
    for (int k = 0; k < 12; k++) begin
      logic        hi, ex, e_ale, e_ps, e_rd, e_wr, e_oe;
      logic [3:0]  o;
      logic [15:0] fa;
      logic [7:0]  e_p0, e_p2, drv;
      @(negedge clk);
      // R2: scramble the command inputs inside the cycle; pins must not follow.
      if (k != 11) begin
        cmd_kind = 2'($urandom); cmd_addr = 16'($urandom);
        cmd_wdata = 8'($urandom); ext_access = 1'($urandom);
      end
      hi = (k >= 6); o = hi ? 4'(k - 6) : 4'(k);
      fa = addr + 16'(hi); ex = is_ext(ext, fa);
      e_ale = 0; e_ps = 1; e_rd = 1; e_wr = 1; e_oe = 0; e_p0 = 0; e_p2 = 0;
      drv = 8'($urandom);
      case (kind)
        2'd1: begin
          e_ale = (o < 2); e_p2 = fa[15:8];
          if (ex) begin
            e_ps = !(o >= 3);
            if (o < 3) begin e_oe = 1; e_p0 = fa[7:0]; end
            if (o == 5) drv = xprog(fa);
          end
        end
        2'd2, 2'd3: begin
          e_ale = (k < 2); e_p2 = addr[15:8];
          if (k < 3) begin e_oe = 1; e_p0 = addr[7:0]; end
          if (kind == 2'd2) begin
            e_rd = !(k >= 3 && k <= 8);
            if (k == 8) drv = xdata(addr);
          end else begin
            e_wr = !(k >= 3 && k <= 8);
            if (k >= 3 && k <= 8) begin e_oe = 1; e_p0 = wd; end
          end
        end
        default: ;
      endcase
      chk(ptag, {59'd0, ale, psen_n, rd_n, wr_n, p0_oe}, {59'd0, e_ale, e_ps, e_rd, e_wr, e_oe});
      if (e_oe) chk(ptag, {56'd0, p0_out}, {56'd0, e_p0});
      if (kind != 2'd0) chk(ptag, {56'd0, p2_out}, {56'd0, e_p2});
      if (kind == 2'd1 && !ex) chk("R5 rom_addr", {48'd0, rom_addr}, {48'd0, fa});
      chk("R11 one strobe", {63'd0, ($countones({~psen_n, ~rd_n, ~wr_n}) <= 1)}, 64'd1);
      chk("R1 cyc_last", {63'd0, cyc_last}, {63'd0, (k == 11)});
      // Result pulses.
      if (k == 0) begin
        chk(fd_tag, {63'd0, fetch_valid}, {63'd0, fv_pend});
        if (fv_pend) chk(fd_tag, {56'd0, fetch_data}, {56'd0, fd_pend});
      end else if (k == 6) begin
        logic [7:0] e0;
        string t0;
        e0 = is_ext(ext, addr) ? xprog(addr) : rom_fn(addr);
        t0 = ext ? "R6" : (is_ext(ext, addr) ? "R4" : "R5");
        chk(t0, {63'd0, fetch_valid}, {63'd0, (kind == 2'd1)});
        if (kind == 2'd1) chk(t0, {56'd0, fetch_data}, {56'd0, e0});
      end else begin
        chk("R4 valid idle", {63'd0, fetch_valid}, 64'd0);
      end
      if (k == 9) begin
        chk("R7 rd_valid", {63'd0, rd_valid}, {63'd0, (kind == 2'd2)});
        if (kind == 2'd2) chk("R7 rd_data", {56'd0, rd_data}, {56'd0, xdata(addr)});
      end else begin
        chk("R7 rd_valid idle", {63'd0, rd_valid}, 64'd0);
      end
      p0_in = drv;
    end
    fv_pend = (kind == 2'd1);
    fa = addr + 16'd1;
    fd_pend = is_ext(ext, fa) ? xprog(fa) : rom_fn(fa);
    fd_tag = ext ? "R6" : (is_ext(ext, fa) ? "R4" : "R5");
  endtask

  logic [15:0] fa;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    p0_in = 8'h00;
    repeat (3) @(negedge clk);
    // R10: reset state.
    chk("R10 strobes", {59'd0, ale, psen_n, rd_n, wr_n, p0_oe}, {59'd0, 5'b01110});
    chk("R10 valids", {62'd0, fetch_valid, rd_valid}, 64'd0);
    chk("R1 cyc_last in reset", {63'd0, cyc_last}, 64'd1);
    rst = 1'b0;
    run_cycle(2'd0, 16'h1234, 8'h00, 1'b0);   // R9 idle
    run_cycle(2'd1, 16'h1FFF, 8'h00, 1'b0);   // R5 halves straddle limit
    run_cycle(2'd1, 16'hFFFF, 8'h00, 1'b0);   // R5 wrap to internal
    run_cycle(2'd1, 16'h0100, 8'h00, 1'b1);   // R6 forced external
    run_cycle(2'd1, 16'h0100, 8'h00, 1'b0);   // R5 both internal
    run_cycle(2'd2, 16'hBEEF, 8'h00, 1'b0);   // R7
    run_cycle(2'd3, 16'h4321, 8'hA7, 1'b1);   // R8
    run_cycle(2'd1, 16'h8000, 8'h00, 1'b0);   // R4 both external
    for (int i = 0; i < 150; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if (($urandom % 4) == 0) a = {3'b000, 13'h1FFF - 13'($urandom % 2)} | 16'((a[15] ? 16'hE000 : 16'h0));
      run_cycle(2'($urandom), a, 8'($urandom), 1'($urandom));
    end
    run_cycle(2'd0, 16'h0000, 8'h00, 1'b0);   // flush final half-1 pulse
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule